// File: doc/BRIEF.md
# Two-Side Timestamp Coincidence Pairer

This block receives trigger timestamps from two independent acquisition sides, called head and tail, and decides for each one whether it is a lone event (a single) or part of a head/tail coincidence. Records enter on a valid/ready input, each carrying a 40-bit timestamp and a side bit. They are held in a small buffer that is always kept in timestamp order. Records from the two sides may arrive in any relative order.

The block does not decide an entry too early. It waits until the buffer covers enough time: the newest held timestamp minus the earliest must be larger than a programmable spread. A later arrival therefore still has the chance to pair with an earlier one. The earliest entry is then compared with every other held entry. If an entry from the opposite side lies within a programmable match window, both are reported as a coincidence and the partner is marked as consumed. Otherwise the earliest entry is reported as a single. A flush input empties the buffer at the end of a run.

Top module: `coinc_pairer`

## Requirements
- R1: The entry resolved is always the one with the smallest timestamp held. Entries with equal timestamps are resolved in their arrival order.
- R2: The earliest entry is resolved when the newest timestamp minus the earliest timestamp is strictly greater than `cfg_spread`. A span equal to `cfg_spread` resolves nothing.
- R3: A partner is a held entry whose side differs from the earliest entry, that has not been consumed, and whose timestamp exceeds the earliest by at most `cfg_window` (the bound is inclusive). When such a partner exists, the output has `out_coinc`=1 and `out_partner_ts` holds the partner's timestamp. If several qualify, the one with the smallest timestamp is chosen.
- R4: Two entries with the same side bit are never paired (side encoding: 0 = head, 1 = tail).
- R5: When no partner exists, the earliest entry is emitted with `out_coinc`=0 and `out_partner_ts`=0.
- R6: A partner used in a coincidence is marked as consumed. When it later becomes the earliest entry, it is removed without producing an output.
- R7: When the buffer holds DEPTH (8) entries, `in_ready` is 0 and the earliest entry is resolved whatever the span.
- R8: A one-cycle `flush` pulse causes all held entries to be resolved, one per cycle, in timestamp order. `in_ready` stays 0 until the buffer is empty.
- R9: After reset the buffer is empty, `in_ready` is 1 and `out_valid` is 0.
- R10: Every emitted result appears as exactly one registered cycle of `out_valid`, in the cycle after its resolution. Consumed entries produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Block can accept a record this cycle |
| in_side | input | 1 | Source side of the record: 0 head, 1 tail |
| in_ts | input | TS_W | Trigger timestamp of the record |
| flush | input | 1 | Pulse: resolve every held entry |
| cfg_spread | input | TS_W | Span that must be exceeded before resolving |
| cfg_window | input | TS_W | Largest timestamp gap accepted as a coincidence |
| out_valid | output | 1 | Result record present for one cycle |
| out_side | output | 1 | Side of the resolved entry |
| out_ts | output | TS_W | Timestamp of the resolved entry |
| out_coinc | output | 1 | 1 when paired, 0 for a single |
| out_partner_ts | output | TS_W | Partner timestamp, 0 for a single |

## Verification
The bench targets several boundaries. A span exactly equal to the spread must not resolve; a design that used greater-or-equal would emit early and break pairs that were still forming. A gap exactly equal to the window must pair, while a gap one tick larger must not; an off-by-one design reports two singles in place of a coincidence, or the reverse. Same-side neighbours and triples of the form head, tail, head check that a design does not pair same-side entries and does not report a consumed partner a second time. A randomly interleaved, out-of-order stream against a reference queue also tests full-buffer back-pressure and flush draining; a design that stalled when full, or left entries behind after a flush, would lose records.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int unsigned TS_BITS_DEF = 40;
  localparam int unsigned SLOTS_DEF   = 8;

  typedef enum logic {
    SIDE_HEAD = 1'b0,
    SIDE_TAIL = 1'b1
  } side_e;
endpackage

// File: rtl/coinc_insert_pos.sv
// Finds the slot a new timestamp takes in the sorted store: after every
// valid entry whose timestamp is less than or equal to it (stable for ties).
module coinc_insert_pos #(
  parameter int TS_W  = 40,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][TS_W-1:0] ts_q,
  input  logic [CNT_W-1:0]           count,
  input  logic [TS_W-1:0]            new_ts,
  output logic [CNT_W-1:0]           pos
);
  logic [DEPTH-1:0] not_after;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      not_after[k] = (CNT_W'(k) < count) && (ts_q[k] <= new_ts);
    end
    pos = CNT_W'($countones(not_after));
  end
endmodule

// File: rtl/coinc_match_find.sv
// Scans entries 1..count-1 for the first unconsumed opposite-side entry
// lying within the match window of entry 0.
module coinc_match_find #(
  parameter int TS_W  = 40,
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][TS_W-1:0] ts_q,
  input  logic [DEPTH-1:0]           side_q,
  input  logic [DEPTH-1:0]           used_q,
  input  logic [CNT_W-1:0]           count,
  input  logic [TS_W-1:0]            window,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx
);
  logic [DEPTH-1:0] cand;

  assign cand[0] = 1'b0;

  genvar g;
  generate
    for (g = 1; g < DEPTH; g++) begin : g_cand
      logic [TS_W-1:0] gap;
      assign gap     = ts_q[g] - ts_q[0];
      assign cand[g] = (CNT_W'(g) < count) && !used_q[g] &&
                       (side_q[g] != side_q[0]) && (gap <= window);
    end
  endgenerate

  // Lowest index wins: sorted order makes it the earliest partner.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = DEPTH - 1; k >= 1; k--) begin
      if (cand[k]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/coinc_sorted_buf.sv
// Time-ordered entry store. One operation per cycle: insert at a slot
// (entries above move up) or pop slot 0 (all entries move down), with an
// optional consumed mark applied to one slot during the pop.
module coinc_sorted_buf #(
  parameter int TS_W  = 40,
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [CNT_W-1:0]           push_pos,
  input  logic [TS_W-1:0]            push_ts,
  input  logic                       push_side,
  input  logic                       pop,
  input  logic                       mark,
  input  logic [IDX_W-1:0]           mark_idx,
  output logic [DEPTH-1:0][TS_W-1:0] ts_q,
  output logic [DEPTH-1:0]           side_q,
  output logic [DEPTH-1:0]           used_q,
  output logic [CNT_W-1:0]           count
);
  logic [DEPTH-1:0][TS_W-1:0] ts_n, ts_dn, ts_up;
  logic [DEPTH-1:0]           side_n, side_dn, side_up;
  logic [DEPTH-1:0]           used_n, used_dn, used_up, used_m, mark_oh;

  assign mark_oh = mark ? (DEPTH'(1) << mark_idx) : '0;
  assign used_m  = used_q | mark_oh;

  // Slot k of *_dn holds slot k+1; slot k of *_up holds slot k-1.
  assign ts_dn   = {{TS_W{1'b0}}, ts_q[DEPTH-1:1]};
  assign side_dn = {1'b0, side_q[DEPTH-1:1]};
  assign used_dn = {1'b0, used_m[DEPTH-1:1]};
  assign ts_up   = {ts_q[DEPTH-2:0], {TS_W{1'b0}}};
  assign side_up = {side_q[DEPTH-2:0], 1'b0};
  assign used_up = {used_q[DEPTH-2:0], 1'b0};

  always_comb begin
    ts_n   = ts_q;
    side_n = side_q;
    used_n = used_q;
    if (pop) begin
      ts_n   = ts_dn;
      side_n = side_dn;
      used_n = used_dn;
    end else if (push) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (CNT_W'(k) == push_pos) begin
          ts_n[k]   = push_ts;
          side_n[k] = push_side;
          used_n[k] = 1'b0;
        end else if (CNT_W'(k) > push_pos) begin
          ts_n[k]   = ts_up[k];
          side_n[k] = side_up[k];
          used_n[k] = used_up[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q   <= '0;
      side_q <= '0;
      used_q <= '0;
      count  <= '0;
    end else begin
      ts_q   <= ts_n;
      side_q <= side_n;
      used_q <= used_n;
      if (pop)       count <= count - CNT_W'(1);
      else if (push) count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/coinc_pairer.sv
module coinc_pairer
  import coinc_pkg::*;
#(
  parameter int TS_W  = TS_BITS_DEF,
  parameter int DEPTH = SLOTS_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_side,
  input  logic [TS_W-1:0] in_ts,
  input  logic            flush,
  input  logic [TS_W-1:0] cfg_spread,
  input  logic [TS_W-1:0] cfg_window,
  output logic            out_valid,
  output logic            out_side,
  output logic [TS_W-1:0] out_ts,
  output logic            out_coinc,
  output logic [TS_W-1:0] out_partner_ts
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][TS_W-1:0] ts_q;
  logic [DEPTH-1:0]           side_q, used_q;
  logic [CNT_W-1:0]           count, ins_pos;
  logic [IDX_W-1:0]           last_idx, hit_idx;
  logic [TS_W-1:0]            span;
  logic                       hit, resolve, push, emit, flush_act;

  assign last_idx = IDX_W'(count - CNT_W'(1));
  assign span     = ts_q[last_idx] - ts_q[0];

  // Resolve the earliest entry on a wide enough span, a full store or a flush.
  assign resolve  = (count != '0) &&
                    (flush_act || (count == CNT_W'(DEPTH)) || (span > cfg_spread));
  assign in_ready = !resolve && !flush_act && (count < CNT_W'(DEPTH));
  assign push     = in_valid && in_ready;
  assign emit     = resolve && !used_q[0];

  coinc_insert_pos #(.TS_W(TS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_pos (
    .ts_q   (ts_q),
    .count  (count),
    .new_ts (in_ts),
    .pos    (ins_pos)
  );

  coinc_match_find #(.TS_W(TS_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_find (
    .ts_q    (ts_q),
    .side_q  (side_q),
    .used_q  (used_q),
    .count   (count),
    .window  (cfg_window),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  coinc_sorted_buf #(.TS_W(TS_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_pos  (ins_pos),
    .push_ts   (in_ts),
    .push_side (in_side),
    .pop       (resolve),
    .mark      (emit && hit),
    .mark_idx  (hit_idx),
    .ts_q      (ts_q),
    .side_q    (side_q),
    .used_q    (used_q),
    .count     (count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_act <= 1'b0;
    end else if (flush) begin
      flush_act <= 1'b1;
    end else if ((count == '0) || ((count == CNT_W'(1)) && resolve)) begin
      flush_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_side       <= 1'b0;
      out_ts         <= '0;
      out_coinc      <= 1'b0;
      out_partner_ts <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_side       <= side_q[0];
        out_ts         <= ts_q[0];
        out_coinc      <= hit;
        out_partner_ts <= hit ? ts_q[hit_idx] : '0;
      end
    end
  end
endmodule

// File: rtl/coinc_pairer_chk.sv
module coinc_pairer_chk #(
  parameter int TS_W  = 40,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             flush_act,
  input logic [CNT_W-1:0] count,
  input logic             out_valid,
  input logic [TS_W-1:0]  out_ts,
  input logic             out_coinc,
  input logic [TS_W-1:0]  out_partner_ts,
  input logic [TS_W-1:0]  cfg_window
);
  // R7
  full_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !in_ready);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R8
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    flush_act |-> !in_ready);

  // R3
  coinc_window_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_coinc) |->
      ((out_partner_ts >= out_ts) && ((out_partner_ts - out_ts) <= $past(cfg_window))));

  // R5
  single_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_coinc) |-> (out_partner_ts == '0));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready));
endmodule

bind coinc_pairer coinc_pairer_chk #(.TS_W(TS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_ready       (in_ready),
  .flush_act      (flush_act),
  .count          (count),
  .out_valid      (out_valid),
  .out_ts         (out_ts),
  .out_coinc      (out_coinc),
  .out_partner_ts (out_partner_ts),
  .cfg_window     (cfg_window)
);

// File: tb/coinc_pairer_test.sv
module coinc_pairer_test;
  import coinc_pkg::*;

  localparam int TS_W       = 40;
  localparam int DEPTH      = 8;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_MAX    = 1024;
  localparam int N_STIM     = 16;
  localparam int N_RAND     = 300;

  // Stimulus vectors: {side, timestamp}; results come from the reference queue.
  localparam logic [TS_W:0] STIM [N_STIM] = '{
    {1'b0, 40'd5100}, {1'b1, 40'd5105}, {1'b1, 40'd5130}, {1'b0, 40'd5128},
    {1'b0, 40'd5300}, {1'b1, 40'd5290}, {1'b0, 40'd5500}, {1'b1, 40'd5520},
    {1'b1, 40'd5700}, {1'b0, 40'd5721}, {1'b0, 40'd5900}, {1'b0, 40'd5905},
    {1'b1, 40'd6200}, {1'b0, 40'd6195}, {1'b1, 40'd6400}, {1'b0, 40'd6421}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_side = 1'b0;
  logic [TS_W-1:0] in_ts = '0;
  logic            flush = 1'b0;
  logic [TS_W-1:0] cfg_spread = 40'd100;
  logic [TS_W-1:0] cfg_window = 40'd20;
  logic            out_valid, out_side, out_coinc;
  logic [TS_W-1:0] out_ts, out_partner_ts;

  int n_tests = 0;
  int n_fail  = 0;
  int out_seen = 0;
  int coinc_seen = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_tag = "R9";

  // reference queue
  logic [TS_W-1:0] m_ts   [DEPTH];
  logic            m_side [DEPTH];
  logic            m_used [DEPTH];
  int              m_cnt = 0;

  logic [TS_W-1:0] e_ts  [EXP_MAX];
  logic [TS_W-1:0] e_pts [EXP_MAX];
  logic            e_side[EXP_MAX];
  logic            e_co  [EXP_MAX];
  int wr = 0;
  int rd = 0;

  coinc_pairer #(.TS_W(TS_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_side(in_side), .in_ts(in_ts), .flush(flush),
    .cfg_spread(cfg_spread), .cfg_window(cfg_window),
    .out_valid(out_valid), .out_side(out_side), .out_ts(out_ts),
    .out_coinc(out_coinc), .out_partner_ts(out_partner_ts)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic m_resolve();
    int hk;
    hk = -1;
    if (!m_used[0]) begin
      for (int k = 1; k < m_cnt; k++) begin
        if (hk < 0 && !m_used[k] && m_side[k] != m_side[0] &&
            (m_ts[k] - m_ts[0]) <= cfg_window) hk = k;
      end
      e_ts[wr]   = m_ts[0];
      e_side[wr] = m_side[0];
      e_co[wr]   = (hk > 0);
      e_pts[wr]  = (hk > 0) ? m_ts[hk] : '0;
      wr++;
      if (hk > 0) m_used[hk] = 1'b1;
    end
    for (int k = 0; k < m_cnt - 1; k++) begin
      m_ts[k] = m_ts[k+1]; m_side[k] = m_side[k+1]; m_used[k] = m_used[k+1];
    end
    m_cnt--;
  endtask

  task automatic m_push(input logic s, input logic [TS_W-1:0] t);
    int p;
    p = 0;
    for (int k = 0; k < m_cnt; k++) if (m_ts[k] <= t) p++;
    for (int k = m_cnt; k > p; k--) begin
      m_ts[k] = m_ts[k-1]; m_side[k] = m_side[k-1]; m_used[k] = m_used[k-1];
    end
    m_ts[p] = t; m_side[p] = s; m_used[p] = 1'b0;
    m_cnt++;
    while (m_cnt > 0 && (m_cnt == DEPTH || (m_ts[m_cnt-1] - m_ts[0]) > cfg_spread))
      m_resolve();
  endtask

  // Called at a falling edge; leaves at the falling edge after acceptance.
  task automatic send(input logic s, input logic [TS_W-1:0] t);
    in_valid = 1'b1; in_side = s; in_ts = t;
    while (!in_ready) @(negedge clk);
    m_push(s, t);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    while (m_cnt > 0) m_resolve();
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic drain();
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // output monitor: every result compared with the reference queue (R1 R3 R5 R10)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      out_seen++;
      if (out_coinc) coinc_seen++;
      if (rd >= wr) begin
        n_tests++; n_fail++;
        $display("FAIL R10 (%s): got extra output ts=%0d expected none", cur_tag, out_ts);
      end else begin
        chk($sformatf("R1 R3 R5 (%s) record %0d", cur_tag, rd),
            {out_side, out_coinc, out_ts, out_partner_ts},
            {e_side[rd], e_co[rd], e_ts[rd], e_pts[rd]});
        rd++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int base_out, base_co;
    logic [31:0] r;
    logic [TS_W-1:0] base;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: idle after reset
    chk("R9 in_ready", in_ready, 1'b1);
    chk("R9 out_valid", out_valid, 1'b0);

    // table walk: spread 100, window 20 (window edge 20 pairs, 21 does not)
    cur_tag = "R1";
    for (int i = 0; i < N_STIM; i++) send(STIM[i][TS_W], STIM[i][TS_W-1:0]);
    do_flush();
    drain();

    // R2: span equal to spread resolves nothing
    cur_tag = "R2";
    base_out = out_seen;
    send(SIDE_HEAD, 40'd10000);
    send(SIDE_TAIL, 40'd10100);
    repeat (4) @(negedge clk);
    chk("R2 no resolve at span==spread", out_seen - base_out, 0);
    send(SIDE_HEAD, 40'd10101);
    repeat (4) @(negedge clk);
    chk("R2 one resolve at span>spread", out_seen - base_out, 1);
    do_flush();
    drain();
    chk("R2 flush total", out_seen - base_out, 2);

    // R4: same side never paired
    cur_tag = "R4";
    base_out = out_seen; base_co = coinc_seen;
    send(SIDE_HEAD, 40'd20000);
    send(SIDE_HEAD, 40'd20005);
    do_flush();
    drain();
    chk("R4 outputs", out_seen - base_out, 2);
    chk("R4 no coincidence", coinc_seen - base_co, 0);

    // R6: consumed partner is not reported again
    cur_tag = "R6";
    base_out = out_seen; base_co = coinc_seen;
    send(SIDE_HEAD, 40'd30000);
    send(SIDE_TAIL, 40'd30005);
    send(SIDE_HEAD, 40'd30008);
    do_flush();
    drain();
    chk("R6 outputs", out_seen - base_out, 2);
    chk("R6 coincidences", coinc_seen - base_co, 1);

    // R7: full store back-pressures and resolves
    cur_tag = "R7";
    cfg_spread = '1; cfg_window = '0;
    base_out = out_seen;
    for (int i = 0; i < DEPTH; i++) send(SIDE_HEAD, TS_W'(40000 + i));
    chk("R7 in_ready low when full", in_ready, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 one forced resolve", out_seen - base_out, 1);
    do_flush();
    drain();
    chk("R7 all drained", out_seen - base_out, DEPTH);

    // R8: flush drains everything in order
    cur_tag = "R8";
    cfg_window = 40'd50;
    base_out = out_seen; base_co = coinc_seen;
    send(SIDE_HEAD, 40'd50000);
    send(SIDE_TAIL, 40'd50030);
    send(SIDE_TAIL, 40'd50010);
    repeat (3) @(negedge clk);
    chk("R8 nothing before flush", out_seen - base_out, 0);
    do_flush();
    chk("R8 in_ready low while flushing", in_ready, 1'b0);
    drain();
    chk("R8 outputs", out_seen - base_out, 2);
    chk("R8 coincidences", coinc_seen - base_co, 1);

    // random interleaved, out-of-order stream
    cur_tag = "R1";
    cfg_spread = 40'd64; cfg_window = 40'd10;
    base = 40'd100000;
    r = 32'h1234_5678;
    for (int i = 0; i < N_RAND; i++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      base = base + TS_W'(r[3:1]);
      send(r[0], base + TS_W'(r[7:4]));
    end
    do_flush();
    drain();

    // R10: one pulse per expected record
    chk("R10 result count", rd, wr);
    chk("R10 buffer empty", in_ready, 1'b1);
    finish_run();
  end
endmodule